// File: doc/BRIEF.md
# Seven-Level Staircase Gate Sequencer

This block produces the switch commands for a seven-switch inverter that builds a stepped output of seven levels (zero and one, two or three source units of either sign). It switches at the fundamental only: each switch changes state a few times per output period, at fixed angles picked to cancel the third and fifth harmonics. A 32-bit phase accumulator advances by a programmable increment on each enabled clock, which sets the output frequency. A 50 Hz output needs an increment of about 50 · 2^32 / f_clk.

The phase is folded into the first quarter-wave and compared against three angle thresholds. The result is a magnitude from 0 to 3, and the top phase bit gives its sign. The signed level is decoded into a 7-bit gate word. A dead-time stage drops released gates at once and holds newly requested gates off for a programmable number of clocks. A pulse marks the start of each output period.

Top module: `stair_gate_seq`

## Requirements
- R1: On every clock with `en` high, the internal phase advances by `phase_inc` modulo 2^32. `cycle_start_o` is high for the one cycle after an addition that carried out of bit 31, and low otherwise.
- R2: `level_o` (3-bit two's complement) holds, one clock later, the level of the phase value. The lower 30 bits form the quarter-wave offset. When phase bit 30 is set, that offset is mirrored as 2^30 minus the offset. The magnitude is 1, 2 or 3 once the folded value reaches 104589017, 342268349 or 655453744 (about 8.77°, 28.69°, 54.94°), and 0 below the first.
- R3: Phase bit 31 selects the negative half-cycle, whose level is the negation of the positive one. Phase 2^30 gives +3, 2^31 gives 0 and 3·2^30 gives −3.
- R4: Gate bit k drives switch Q(k+1). The settled patterns are: +1 = 0x09, +2 = 0x19, +3 = 0x49, −1 = 0x06, −2 = 0x16, −3 = 0x46.
- R5: At level 0 all seven gates are off.
- R6: When the decoded pattern changes and `dead_cycles` is D > 0, the gates become old AND new one clock after the level change. The full new pattern appears D clocks after that.
- R7: With `dead_cycles` = 0, the new pattern appears in full one clock after the level change.
- R8: A clock with `en` low clears the phase, level, gates and period pulse, and the next enabled period restarts from phase 0.
- R9: Driving `rst_n` low forces all gates off and the level to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low clears the phase and switches off |
| phase_inc | input | 32 | Phase advance per clock |
| dead_cycles | input | 8 | Turn-on delay in clocks |
| gate_o | output | 7 | Gate commands, bit k drives Q(k+1) |
| level_o | output | 3 | Current signed level, −3 to +3 |
| cycle_start_o | output | 1 | One-clock pulse at each phase wrap |

## Verification
A phase accumulator that drifts by even one increment shows up as a level step one clock early or late at the next threshold crossing. It also moves the period pulse, so with a coarse increment the error appears within a few clocks. A corrupted dead-time counter or pending flag shows as a gate word that disagrees with the settled pattern once D+1 clocks have passed since a level change. It can also show as a bit that rises earlier than that. A stale level register shows as gates left on while the level reads zero.

// File: rtl/stair_pkg.sv
package stair_pkg;
  localparam int GATE_W = 7;
  localparam int LVL_W  = 3;

  typedef logic signed [LVL_W-1:0] lvl_t;

  // bit k drives switch Q(k+1)
  function automatic logic [GATE_W-1:0] gate_map(input lvl_t l);
    logic [GATE_W-1:0] g;
    case (l)
      3'sd1:   g = 7'b000_1001;
      3'sd2:   g = 7'b001_1001;
      3'sd3:   g = 7'b100_1001;
      -3'sd1:  g = 7'b000_0110;
      -3'sd2:  g = 7'b001_0110;
      -3'sd3:  g = 7'b100_0110;
      default: g = '0;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/stair_phase_acc.sv
module stair_phase_acc #(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic [PHASE_W-1:0] inc_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic               wrap_o
);
  logic [PHASE_W-1:0] acc_q, acc_d;
  logic               wrap_q, wrap_d;
  logic [PHASE_W:0]   sum;

  always_comb begin
    sum = {1'b0, acc_q} + {1'b0, inc_i};
    if (en_i) begin
      acc_d  = sum[PHASE_W-1:0];
      wrap_d = sum[PHASE_W];
    end else begin
      acc_d  = '0;
      wrap_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      wrap_q <= wrap_d;
    end
  end

  assign phase_o = acc_q;
  assign wrap_o  = wrap_q;

  assert_disable_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (acc_q == '0 && !wrap_q));
endmodule

// File: rtl/stair_level_slicer.sv
module stair_level_slicer
  import stair_pkg::*;
#(
  parameter int               PHASE_W = 32,
  parameter logic [PHASE_W-1:0] TH1   = 32'd104589017,
  parameter logic [PHASE_W-1:0] TH2   = 32'd342268349,
  parameter logic [PHASE_W-1:0] TH3   = 32'd655453744
) (
  input  logic [PHASE_W-1:0] phase_i,
  output lvl_t               level_o
);
  localparam int NSTEP = 3;
  localparam int FW    = PHASE_W - 1;
  localparam logic [FW-1:0] QTR = FW'(1) << (PHASE_W - 2);
  localparam logic [NSTEP-1:0][PHASE_W-1:0] TH = {TH3, TH2, TH1};

  logic [FW-1:0]    fold;
  logic [NSTEP-1:0] hit;
  logic [1:0]       mag;

  always_comb begin
    if (phase_i[PHASE_W-2])
      fold = QTR - {2'b00, phase_i[PHASE_W-3:0]};
    else
      fold = {2'b00, phase_i[PHASE_W-3:0]};
  end

  for (genvar i = 0; i < NSTEP; i++) begin : g_cmp
    assign hit[i] = ({1'b0, fold} >= TH[i]);
  end

  always_comb begin
    mag = '0;
    for (int i = 0; i < NSTEP; i++)
      if (hit[i]) mag = mag + 2'd1;
    if (phase_i[PHASE_W-1])
      level_o = -$signed({1'b0, mag});
    else
      level_o = $signed({1'b0, mag});
  end
endmodule

// File: rtl/stair_deadtime.sv
module stair_deadtime
  import stair_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [DT_W-1:0]   dead_i,
  input  logic [GATE_W-1:0] goal_i,
  output logic [GATE_W-1:0] gate_o
);
  logic [GATE_W-1:0] prev_q, prev_d, g_q, g_d;
  logic [DT_W-1:0]   cnt_q, cnt_d;
  logic              pend_q, pend_d;

  always_comb begin
    prev_d = goal_i;
    g_d    = g_q;
    cnt_d  = cnt_q;
    pend_d = pend_q;
    if (!en_i) begin
      prev_d = '0;
      g_d    = '0;
      cnt_d  = '0;
      pend_d = 1'b0;
    end else if (goal_i != prev_q) begin
      if (dead_i == '0) begin
        g_d    = goal_i;
        pend_d = 1'b0;
      end else begin
        g_d    = g_q & goal_i;
        cnt_d  = dead_i - 1'b1;
        pend_d = 1'b1;
      end
    end else if (pend_q) begin
      if (cnt_q == '0) begin
        g_d    = goal_i;
        pend_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      g_q    <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      g_q    <= g_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign gate_o = g_q;

  // upper and lower leg pairs, and the two source-stacking switches, never together
  assert_no_shoot_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !((g_q[0] | g_q[3]) & (g_q[1] | g_q[2])) && !(g_q[4] & g_q[6]));

  assert_turn_on_after_dead_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(g_q & ~$past(g_q))) |-> ($past(pend_q) || $past(dead_i) == '0));
endmodule

// File: rtl/stair_gate_seq.sv
module stair_gate_seq
  import stair_pkg::*;
#(
  parameter int                 PHASE_W = 32,
  parameter int                 DT_W    = 8,
  parameter logic [PHASE_W-1:0] TH1     = 32'd104589017,
  parameter logic [PHASE_W-1:0] TH2     = 32'd342268349,
  parameter logic [PHASE_W-1:0] TH3     = 32'd655453744
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [PHASE_W-1:0] phase_inc,
  input  logic [DT_W-1:0]    dead_cycles,
  output logic [6:0]         gate_o,
  output logic signed [2:0]  level_o,
  output logic               cycle_start_o
);
  logic              rs_meta_q, rs_n;
  logic [PHASE_W-1:0] phase;
  lvl_t              slice_lvl, lvl_q, lvl_d;
  logic [GATE_W-1:0] goal;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_n      <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_n      <= rs_meta_q;
    end
  end

  stair_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk(clk), .rst_n(rs_n), .en_i(en), .inc_i(phase_inc),
    .phase_o(phase), .wrap_o(cycle_start_o)
  );

  stair_level_slicer #(.PHASE_W(PHASE_W), .TH1(TH1), .TH2(TH2), .TH3(TH3)) u_slice (
    .phase_i(phase), .level_o(slice_lvl)
  );

  always_comb lvl_d = en ? slice_lvl : lvl_t'(0);

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) lvl_q <= '0;
    else       lvl_q <= lvl_d;
  end

  assign goal = gate_map(lvl_q);

  stair_deadtime #(.DT_W(DT_W)) u_dead (
    .clk(clk), .rst_n(rs_n), .en_i(en), .dead_i(dead_cycles),
    .goal_i(goal), .gate_o(gate_o)
  );

  assign level_o = lvl_q;

  assert_zero_level_all_off_R5: assert property (@(posedge clk) disable iff (!rs_n)
    (lvl_q == 0 && $past(lvl_q) == 0) |-> (gate_o == '0));
endmodule

// File: tb/sim_stair_gate_seq.sv
module sim_stair_gate_seq;
  localparam logic [31:0] T1 = 32'd104589017;
  localparam logic [31:0] T2 = 32'd342268349;
  localparam logic [31:0] T3 = 32'd655453744;

  // {phase increment, dead cycles, cycles to run, expected peak level}
  localparam int NV = 6;
  localparam logic [31:0] VEC [NV][4] = '{
    '{32'h0400_0000, 32'd0,   32'd200,  32'd3},
    '{32'h0100_0000, 32'd5,   32'd600,  32'd3},
    '{32'h4000_0000, 32'd0,   32'd40,   32'd3},
    '{32'h8000_0000, 32'd0,   32'd20,   32'd0},
    '{32'h0008_0000, 32'd255, 32'd8300, 32'd3},
    '{32'd3,         32'd2,   32'd50,   32'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [31:0] phase_inc = '0;
  logic [7:0]  dead_cycles = '0;
  logic [6:0]  gate_o;
  logic signed [2:0] level_o;
  logic        cycle_start_o;

  int total = 0, fails = 0;
  logic [31:0] acc_m = '0;
  int cur_l = 0, old_l = 0, age = 1000000, peak = 0;

  always #4 clk = ~clk;

  stair_gate_seq u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .phase_inc(phase_inc),
    .dead_cycles(dead_cycles), .gate_o(gate_o), .level_o(level_o),
    .cycle_start_o(cycle_start_o)
  );

  function automatic int lvl_of(logic [31:0] p);
    logic [31:0] f;
    int m;
    f = p[30] ? (32'h4000_0000 - {2'b00, p[29:0]}) : {2'b00, p[29:0]};
    m = (f >= T3) ? 3 : (f >= T2) ? 2 : (f >= T1) ? 1 : 0;
    return p[31] ? -m : m;
  endfunction

  function automatic int pat(int l);
    case (l)
      1: return 'h09;  2: return 'h19;  3: return 'h49;
      -1: return 'h06; -2: return 'h16; -3: return 'h46;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h) t=%0t", req, act, act, exp, exp, $time);
    end
  endtask

  // one clock, then compare against the model after the edge
  task automatic step();
    int el;
    bit ew;
    logic [32:0] s;
    @(posedge clk);
    #2;
    s  = {1'b0, acc_m} + {1'b0, phase_inc};
    el = en ? lvl_of(acc_m) : 0;
    ew = en && s[32];
    acc_m = en ? s[31:0] : '0;
    if (!en) begin
      cur_l = 0; old_l = 0; age = 1000000;
      chk(gate_o == 0 && level_o == 0 && !cycle_start_o, "R8 disabled clear",
          int'(gate_o), 0);
    end else begin
      if (el != cur_l) begin old_l = cur_l; cur_l = el; age = 0; end
      else age++;
      if (el > peak) peak = el;
      chk(int'(level_o) == el, "R2/R3 level", int'(level_o), el);
      chk(cycle_start_o == ew, "R1 period pulse", int'(cycle_start_o), int'(ew));
      if (age >= int'(dead_cycles) + 1)
        chk(int'(gate_o) == pat(cur_l), (cur_l == 0) ? "R5 level zero off" :
            (dead_cycles == 0) ? "R7 settled gates" : "R4 settled gates",
            int'(gate_o), pat(cur_l));
      else if (age >= 1)
        chk(int'(gate_o) == (pat(old_l) & pat(cur_l)), "R6 dead window",
            int'(gate_o), pat(old_l) & pat(cur_l));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #3;
    chk(gate_o == 0 && level_o == 0 && !cycle_start_o, "R9 reset state", int'(gate_o), 0);
    #10 rst_n = 1'b1;
    repeat (3) step();

    // table walk
    for (int v = 0; v < NV; v++) begin
      phase_inc   = VEC[v][0];
      dead_cycles = VEC[v][1][7:0];
      peak = -4;
      en = 1'b1;
      for (int c = 0; c < int'(VEC[v][2]); c++) step();
      chk(peak == int'(VEC[v][3]), "R2 peak level", peak, int'(VEC[v][3]));
      en = 1'b0;
      repeat (2) step();
    end

    // directed: disable while at +3, restart from zero phase (R8)
    phase_inc = 32'h0400_0000; dead_cycles = 8'd0; en = 1'b1;
    repeat (18) step();
    chk(int'(gate_o) == 'h49, "R4 +3 pattern before disable", int'(gate_o), 'h49);
    en = 1'b0;
    step();
    en = 1'b1;
    step();
    chk(level_o == 0 && gate_o == 0, "R8 restart at phase zero", int'(level_o), 0);
    repeat (17) step();
    chk(int'(level_o) == 3, "R8 restart reaches +3 on schedule", int'(level_o), 3);

    // directed: asynchronous reset with gates on (R9)
    #1 rst_n = 1'b0;
    #1;
    chk(gate_o == 0 && level_o == 0, "R9 async reset", int'(gate_o), 0);
    en = 1'b0;
    #5 rst_n = 1'b1;
    acc_m = '0;
    repeat (3) step();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule